// File: doc/BRIEF.md
# Lookahead-Arbitrated Bypass Mesh Router

One router of a two-dimensional mesh with five ports: local, north, south, east and west. Every input has two channels: an early request channel that names the output a packet will want, and a flit channel that carries the packet itself a fixed `LA` cycles later. Each output runs its arbitration when the early request arrives. The winning input then owns that output before its head flit shows up. When the head arrives on schedule it is steered straight into the output register, with no queue and no arbitration step in its path.

A packet whose early request loses, or whose request was never sent, is written into a shallow per-input FIFO. When it reaches the FIFO head it is arbitrated again, and its output is chosen by dimension-order routing from the destination coordinates in its head flit. An output stays with one packet from its grant until that packet's tail flit has left. Because of this, flits of different packets never mix on a link.

Top module: `la_mesh_router`

## Requirements
- R1: While `rst_ni` is low and on the first cycle after release, every `flit_valid_o` bit is low. Reset discards any grant already issued for a head flit that has not yet arrived, so that head takes the buffered path.
- R2: Port codes are 0 local, 1 north (+y), 2 south (-y), 3 east (+x), 4 west (-x). Flit bit FW-1 is head and bit FW-2 is tail. If an early request on input i for a free output o is granted in cycle t, the head flit arriving on input i in cycle t+LA appears unchanged on output o in cycle t+LA+1.
- R3: Each later flit of a bypassed packet appears on the same output one cycle after it arrives, in arrival order.
- R4: An output is held from its grant until its tail flit leaves. Early and buffered requests for a held output are refused. A packet refused this way takes the buffered path.
- R5: A packet with no grant waiting for its head is buffered. Its head leaves no earlier than two cycles after arrival, and its flits leave in order without interleaving.
- R6: A buffered packet's output comes from its head flit: destination x in data bits [CW-1:0] and y in bits [2CW-1:CW]. X is resolved first (east/west), then Y (north/south), and the local port is used when both match the router's position.
- R7: Each output picks among competing inputs in round-robin order. After a grant to input w, the next search starts at input w+1 modulo 5. The search starts at input 0 after reset.
- R8: At a free output, a buffered request beats any early request in the same cycle, and the early request is refused.
- R9: No flit is lost or duplicated, and on each output every head flit follows a tail flit (or reset) and every non-head flit follows a flit of the same packet.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| la_valid_i | input | 5 | Early request valid, one bit per input |
| la_port_i | input | 5x3 | Requested output code per input |
| flit_valid_i | input | 5 | Flit valid per input |
| flit_i | input | 5xFW | Flit per input (head, tail, data) |
| flit_valid_o | output | 5 | Flit valid per output |
| flit_o | output | 5xFW | Flit per output |

## Verification
The assertions check on every cycle that a bypassed flit only reaches an output already reserved for its input, and that an output carrying a non-tail flit issues no grant. They also check that head and body flits never interleave on an output, that each output issues at most one grant per cycle, and that no FIFO overflows or is popped while empty. Only the bench scenarios can show the exact cycle at which each packet leaves. They also show which input wins under round-robin and under buffered-first priority, that the dimension-order route is correct, that refused packets fall back to the queue, and that a reset drops a grant still waiting for its head.

// File: rtl/la_mesh_pkg.sv
package la_mesh_pkg;
  localparam int unsigned NUM_PORTS = 5;
  localparam int unsigned PORT_W    = 3;

  typedef enum logic [PORT_W-1:0] {
    PORT_LOCAL = 3'd0,
    PORT_NORTH = 3'd1,
    PORT_SOUTH = 3'd2,
    PORT_EAST  = 3'd3,
    PORT_WEST  = 3'd4
  } port_e;

  // dimension order: x first, then y
  function automatic logic [PORT_W-1:0] xy_route(input int cx, input int cy,
                                                 input int dx, input int dy);
    port_e p;
    if (dx > cx)      p = PORT_EAST;
    else if (dx < cx) p = PORT_WEST;
    else if (dy > cy) p = PORT_NORTH;
    else if (dy < cy) p = PORT_SOUTH;
    else              p = PORT_LOCAL;
    return p;
  endfunction
endpackage

// File: rtl/la_rr_arb.sv
module la_rr_arb #(
  parameter int N = 5,
  localparam int IW = (N > 1) ? $clog2(N) : 1
) (
  input  logic [N-1:0]  req_i,
  input  logic [IW-1:0] ptr_i,
  output logic [N-1:0]  gnt_o
);
  always_comb begin
    logic found;
    gnt_o = '0;
    found = 1'b0;
    for (int k = 0; k < N; k++) begin
      int idx;
      idx = (int'(ptr_i) + k) % N;
      if (!found && req_i[idx]) begin
        gnt_o[idx] = 1'b1;
        found      = 1'b1;
      end
    end
  end
endmodule

// File: rtl/la_flit_fifo.sv
module la_flit_fifo #(
  parameter int W     = 18,
  parameter int DEPTH = 4,
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CW = $clog2(DEPTH + 1)
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         push_i,
  input  logic [W-1:0] wdata_i,
  input  logic         pop_i,
  output logic [W-1:0] rdata_o,
  output logic         empty_o
);
  logic [DEPTH-1:0][W-1:0] mem_q;
  logic [AW-1:0] wp_q, rp_q;
  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wp_q  <= '0;
      rp_q  <= '0;
      cnt_q <= '0;
    end else begin
      if (push_i) wp_q <= (wp_q == AW'(DEPTH-1)) ? '0 : wp_q + 1'b1;
      if (pop_i)  rp_q <= (rp_q == AW'(DEPTH-1)) ? '0 : rp_q + 1'b1;
      cnt_q <= cnt_q + CW'(push_i) - CW'(pop_i);
    end
  end

  always_ff @(posedge clk_i) begin
    if (push_i) mem_q[wp_q] <= wdata_i;
  end

  assign rdata_o = mem_q[rp_q];
  assign empty_o = (cnt_q == '0);

  // R9: no flit dropped at the queue
  a_r9_no_overflow: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (push_i && !pop_i) |-> (cnt_q != CW'(DEPTH)));
  a_r9_no_underflow: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pop_i |-> (cnt_q != '0));
endmodule

// File: rtl/la_in_port.sv
module la_in_port
  import la_mesh_pkg::*;
#(
  parameter int FW    = 18,
  parameter int CW    = 2,
  parameter int LA    = 2,
  parameter int DEPTH = 4,
  parameter int X_POS = 1,
  parameter int Y_POS = 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              flit_valid_i,
  input  logic [FW-1:0]     flit_i,
  input  logic [PORT_W-1:0] la_port_i,
  input  logic              la_gnt_i,
  input  logic              buf_gnt_i,
  input  logic              pop_i,
  output logic              byp_valid_o,
  output logic [PORT_W-1:0] byp_port_o,
  output logic              buf_req_o,
  output logic [PORT_W-1:0] buf_port_o,
  output logic [FW-1:0]     head_flit_o,
  output logic              fifo_empty_o
);
  // grant pipeline: stage LA-1 lines up with the expected head
  logic [LA-1:0]              pv_q;
  logic [LA-1:0][PORT_W-1:0]  pp_q;
  logic                       lb_q;
  logic [PORT_W-1:0]          lp_q;
  logic                       drain_q;
  logic                       to_byp, push;
  logic [PORT_W-1:0]          sel_port;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pv_q <= '0;
      pp_q <= '0;
    end else begin
      pv_q[0] <= la_gnt_i;
      pp_q[0] <= la_port_i;
      for (int k = 1; k < LA; k++) begin
        pv_q[k] <= pv_q[k-1];
        pp_q[k] <= pp_q[k-1];
      end
    end
  end

  always_comb begin
    if (flit_i[FW-1]) begin
      to_byp   = pv_q[LA-1];
      sel_port = pp_q[LA-1];
    end else begin
      to_byp   = lb_q;
      sel_port = lp_q;
    end
  end

  assign byp_valid_o = flit_valid_i && to_byp;
  assign byp_port_o  = sel_port;
  assign push        = flit_valid_i && !to_byp;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      lb_q <= 1'b0;
      lp_q <= '0;
    end else if (flit_valid_i && flit_i[FW-1]) begin
      lb_q <= to_byp;
      lp_q <= sel_port;
    end
  end

  la_flit_fifo #(.W(FW), .DEPTH(DEPTH)) i_fifo (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .push_i  (push),
    .wdata_i (flit_i),
    .pop_i   (pop_i),
    .rdata_o (head_flit_o),
    .empty_o (fifo_empty_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        drain_q <= 1'b0;
    else if (buf_gnt_i) drain_q <= !head_flit_o[FW-2];
    else if (pop_i && head_flit_o[FW-2]) drain_q <= 1'b0;
  end

  assign buf_req_o  = !fifo_empty_o && head_flit_o[FW-1] && !drain_q;
  assign buf_port_o = xy_route(X_POS, Y_POS, int'(head_flit_o[CW-1:0]),
                               int'(head_flit_o[2*CW-1:CW]));
endmodule

// File: rtl/la_out_port.sv
module la_out_port
  import la_mesh_pkg::*;
#(
  parameter int NP   = 5,
  parameter int FW   = 18,
  parameter int PORT = 0,
  localparam int IW = (NP > 1) ? $clog2(NP) : 1
) (
  input  logic                        clk_i,
  input  logic                        rst_ni,
  input  logic [NP-1:0]               la_valid_i,
  input  logic [NP-1:0][PORT_W-1:0]   la_port_i,
  input  logic [NP-1:0]               buf_req_i,
  input  logic [NP-1:0][PORT_W-1:0]   buf_port_i,
  input  logic [NP-1:0]               byp_valid_i,
  input  logic [NP-1:0][PORT_W-1:0]   byp_port_i,
  input  logic [NP-1:0][FW-1:0]       flit_i,
  input  logic [NP-1:0]               fifo_empty_i,
  input  logic [NP-1:0][FW-1:0]       head_flit_i,
  output logic [NP-1:0]               la_gnt_o,
  output logic [NP-1:0]               buf_gnt_o,
  output logic [NP-1:0]               pop_o,
  output logic                        valid_o,
  output logic [FW-1:0]               flit_o
);
  logic [NP-1:0] lreq, breq, lgnt, bgnt;
  logic [IW-1:0] ptr_q, ptr_n, own_q, own_n;
  logic          busy_q, busy_n, srcf_q, srcf_n;
  logic          nv;
  logic [FW-1:0] nf;

  function automatic logic [IW-1:0] oh2idx(input logic [NP-1:0] oh);
    logic [IW-1:0] r;
    r = '0;
    for (int k = 0; k < NP; k++) if (oh[k]) r = IW'(k);
    return r;
  endfunction

  function automatic logic [IW-1:0] next_idx(input logic [IW-1:0] w);
    return (w == IW'(NP-1)) ? '0 : w + 1'b1;
  endfunction

  always_comb begin
    for (int i = 0; i < NP; i++) begin
      lreq[i] = la_valid_i[i] && (la_port_i[i] == PORT_W'(PORT));
      breq[i] = buf_req_i[i]  && (buf_port_i[i] == PORT_W'(PORT));
    end
  end

  la_rr_arb #(.N(NP)) i_arb_buf (.req_i(breq), .ptr_i(ptr_q), .gnt_o(bgnt));
  la_rr_arb #(.N(NP)) i_arb_la  (.req_i(lreq), .ptr_i(ptr_q), .gnt_o(lgnt));

  always_comb begin
    logic [IW-1:0] w;
    la_gnt_o  = '0;
    buf_gnt_o = '0;
    pop_o     = '0;
    nv        = 1'b0;
    nf        = '0;
    busy_n    = busy_q;
    own_n     = own_q;
    srcf_n    = srcf_q;
    ptr_n     = ptr_q;
    w         = '0;
    if (!busy_q) begin
      if (|breq) begin
        // queued packets outrank fresh early requests
        w         = oh2idx(bgnt);
        buf_gnt_o = bgnt;
        pop_o[w]  = 1'b1;
        nv        = 1'b1;
        nf        = head_flit_i[w];
        busy_n    = !head_flit_i[w][FW-2];
        own_n     = w;
        srcf_n    = 1'b1;
        ptr_n     = next_idx(w);
      end else if (|lreq) begin
        w        = oh2idx(lgnt);
        la_gnt_o = lgnt;
        busy_n   = 1'b1;
        own_n    = w;
        srcf_n   = 1'b0;
        ptr_n    = next_idx(w);
      end
    end else if (srcf_q) begin
      if (!fifo_empty_i[own_q]) begin
        pop_o[own_q] = 1'b1;
        nv           = 1'b1;
        nf           = head_flit_i[own_q];
        if (head_flit_i[own_q][FW-2]) busy_n = 1'b0;
      end
    end else if (byp_valid_i[own_q] && byp_port_i[own_q] == PORT_W'(PORT)) begin
      nv = 1'b1;
      nf = flit_i[own_q];
      if (flit_i[own_q][FW-2]) busy_n = 1'b0;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q  <= 1'b0;
      srcf_q  <= 1'b0;
      own_q   <= '0;
      ptr_q   <= '0;
      valid_o <= 1'b0;
      flit_o  <= '0;
    end else begin
      busy_q  <= busy_n;
      srcf_q  <= srcf_n;
      own_q   <= own_n;
      ptr_q   <= ptr_n;
      valid_o <= nv;
      flit_o  <= nv ? nf : '0;
    end
  end

  // checker state: inside a packet on this output
  logic pkt_q;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      pkt_q <= 1'b0;
    else if (valid_o) pkt_q <= !flit_o[FW-2];
  end

  a_r9_no_interleave: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o |-> (flit_o[FW-1] == !pkt_q));
  a_r4_held_refuses: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_o && !flit_o[FW-2]) |-> (la_gnt_o == '0 && buf_gnt_o == '0));
  a_r7_single_grant: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({la_gnt_o, buf_gnt_o}));

  for (genvar i = 0; i < NP; i++) begin : g_own_chk
    // R2: a bypassing flit only reaches an output reserved for its input
    a_r2_byp_owned: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (byp_valid_i[i] && byp_port_i[i] == PORT_W'(PORT))
        |-> (busy_q && !srcf_q && own_q == IW'(i)));
  end
endmodule

// File: rtl/la_mesh_router.sv
module la_mesh_router
  import la_mesh_pkg::*;
#(
  parameter int DATA_W     = 16,
  parameter int CW         = 2,
  parameter int LA         = 2,
  parameter int FIFO_DEPTH = 4,
  parameter int X_POS      = 1,
  parameter int Y_POS      = 1,
  localparam int NP = NUM_PORTS,
  localparam int FW = DATA_W + 2
) (
  input  logic                      clk_i,
  input  logic                      rst_ni,
  input  logic [NP-1:0]             la_valid_i,
  input  logic [NP-1:0][PORT_W-1:0] la_port_i,
  input  logic [NP-1:0]             flit_valid_i,
  input  logic [NP-1:0][FW-1:0]     flit_i,
  output logic [NP-1:0]             flit_valid_o,
  output logic [NP-1:0][FW-1:0]     flit_o
);
  logic [NP-1:0]             byp_valid, buf_req, fifo_empty;
  logic [NP-1:0][PORT_W-1:0] byp_port, buf_port;
  logic [NP-1:0][FW-1:0]     head_flit;
  logic [NP-1:0][NP-1:0]     la_g, buf_g, pop_g;   // [output][input]
  logic [NP-1:0]             la_gnt, buf_gnt, pop;

  always_comb begin
    la_gnt  = '0;
    buf_gnt = '0;
    pop     = '0;
    for (int o = 0; o < NP; o++) begin
      la_gnt  |= la_g[o];
      buf_gnt |= buf_g[o];
      pop     |= pop_g[o];
    end
  end

  for (genvar i = 0; i < NP; i++) begin : g_in
    la_in_port #(
      .FW(FW), .CW(CW), .LA(LA), .DEPTH(FIFO_DEPTH), .X_POS(X_POS), .Y_POS(Y_POS)
    ) i_in (
      .clk_i        (clk_i),
      .rst_ni       (rst_ni),
      .flit_valid_i (flit_valid_i[i]),
      .flit_i       (flit_i[i]),
      .la_port_i    (la_port_i[i]),
      .la_gnt_i     (la_gnt[i]),
      .buf_gnt_i    (buf_gnt[i]),
      .pop_i        (pop[i]),
      .byp_valid_o  (byp_valid[i]),
      .byp_port_o   (byp_port[i]),
      .buf_req_o    (buf_req[i]),
      .buf_port_o   (buf_port[i]),
      .head_flit_o  (head_flit[i]),
      .fifo_empty_o (fifo_empty[i])
    );
  end

  for (genvar o = 0; o < NP; o++) begin : g_out
    la_out_port #(.NP(NP), .FW(FW), .PORT(o)) i_out (
      .clk_i        (clk_i),
      .rst_ni       (rst_ni),
      .la_valid_i   (la_valid_i),
      .la_port_i    (la_port_i),
      .buf_req_i    (buf_req),
      .buf_port_i   (buf_port),
      .byp_valid_i  (byp_valid),
      .byp_port_i   (byp_port),
      .flit_i       (flit_i),
      .fifo_empty_i (fifo_empty),
      .head_flit_i  (head_flit),
      .la_gnt_o     (la_g[o]),
      .buf_gnt_o    (buf_g[o]),
      .pop_o        (pop_g[o]),
      .valid_o      (flit_valid_o[o]),
      .flit_o       (flit_o[o])
    );
  end
endmodule

// File: tb/test_la_mesh_router.sv
`timescale 1ns/1ps
module test_la_mesh_router;
  localparam int NP = 5;
  localparam int DATA_W = 16;
  localparam int FW = DATA_W + 2;
  localparam int LA = 2;
  localparam int NR = 14;
  localparam int LAST_CYC = 80;

  // scenario table, one row per packet
  localparam int T_SRC [NR] = '{4, 1, 0, 0, 2, 3, 0, 4, 0, 1, 3, 2, 1, 3};
  localparam int T_LA  [NR] = '{1, 1, 1, 1, 1, 1, 1, 0, 1, 0, 0, 0, 1, 1};
  localparam int T_REQ [NR] = '{3, 3, 4, 1, 1, 1, 1, 0, 2, 0, 0, 0, 2, 0};
  localparam int T_HD  [NR] = '{10,11,10,20,20,30,30,40,43,50,50,52,60,60};
  localparam int T_LEN [NR] = '{3, 2, 2, 2, 1, 1, 1, 2, 1, 1, 1, 3, 3, 2};
  localparam int T_DX  [NR] = '{3, 2, 0, 1, 1, 1, 1, 1, 1, 1, 0, 3, 1, 1};
  localparam int T_DY  [NR] = '{1, 1, 1, 2, 3, 2, 2, 0, 0, 1, 3, 0, 0, 1};
  localparam int T_EXP [NR] = '{3, 3, 4, 1, 1, 1, 1, 2, 2, 0, 4, 3, 2, 0};
  localparam int T_LAT [NR] = '{1, 3, 1, 1, 3, 1, 2, 2, 2, 2, 2, 2, 1, 1};
  localparam string T_TAG [NR] = '{"R2","R4","R2","R7","R7","R7","R7",
                                   "R5","R8","R6","R6","R6","R2","R2"};

  logic clk = 1'b0;
  logic rst_ni;
  logic [NP-1:0]          la_valid;
  logic [NP-1:0][2:0]     la_port;
  logic [NP-1:0]          fv;
  logic [NP-1:0][FW-1:0]  fin;
  logic [NP-1:0]          ov;
  logic [NP-1:0][FW-1:0]  fout;

  int n_chk = 0;
  int n_err = 0;
  int nidx [NR];
  bit done = 0;

  always #4 clk = ~clk;

  la_mesh_router #(.DATA_W(DATA_W), .CW(2), .LA(LA), .FIFO_DEPTH(4),
                   .X_POS(1), .Y_POS(1)) i_la_mesh_router (
    .clk_i(clk), .rst_ni(rst_ni), .la_valid_i(la_valid), .la_port_i(la_port),
    .flit_valid_i(fv), .flit_i(fin), .flit_valid_o(ov), .flit_o(fout));

  task automatic chk(input bit ok, input string tag, input string what,
                     input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
    end
  endtask

  function automatic logic [FW-1:0] mk_flit(int row, int k, int len, int dx, int dy);
    return {k == 0, k == len - 1, 8'(row), 4'(k), 2'(dy), 2'(dx)};
  endfunction

  task automatic clear_in();
    la_valid = '0; la_port = '0; fv = '0; fin = '0;
  endtask

  task automatic drive(input int c);
    clear_in();
    for (int r = 0; r < NR; r++) begin
      if (T_LA[r] != 0 && c == T_HD[r] - LA) begin
        la_valid[T_SRC[r]] = 1'b1;
        la_port[T_SRC[r]]  = 3'(T_REQ[r]);
      end
      if (c >= T_HD[r] && c < T_HD[r] + T_LEN[r]) begin
        fv[T_SRC[r]]  = 1'b1;
        fin[T_SRC[r]] = mk_flit(r, c - T_HD[r], T_LEN[r], T_DX[r], T_DY[r]);
      end
    end
  endtask

  task automatic monitor(input int c);
    for (int o = 0; o < NP; o++) begin
      if (ov[o]) begin
        int row, k;
        string tag;
        row = int'(fout[o][15:8]);
        k   = int'(fout[o][7:4]);
        if (row >= NR) begin
          chk(0, "R9", "unknown flit row", row, NR - 1);
        end else begin
          tag = (T_LAT[row] == 1 && k > 0) ? "R3" : T_TAG[row];
          chk(o == T_EXP[row], tag, $sformatf("row %0d output port", row), o, T_EXP[row]);
          chk(c == T_HD[row] + T_LAT[row] + k, tag,
              $sformatf("row %0d flit %0d exit cycle", row, k), c,
              T_HD[row] + T_LAT[row] + k);
          chk(k == nidx[row], "R9", $sformatf("row %0d flit order", row), k, nidx[row]);
          chk(fout[o][FW-1] == (k == 0) && fout[o][FW-2] == (k == T_LEN[row] - 1),
              "R9", $sformatf("row %0d head/tail bits", row),
              int'(fout[o][FW-1:FW-2]), (k == 0) * 2 + (k == T_LEN[row] - 1));
          nidx[row]++;
        end
      end
    end
  endtask

  initial begin
    #1600000;
    if (!done) begin
      n_err++;
      $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_err);
      $finish;
    end
  end

  initial begin
    for (int r = 0; r < NR; r++) nidx[r] = 0;
    clear_in();
    rst_ni = 1'b0;
    repeat (3) @(negedge clk);
    chk(ov == '0, "R1", "valid during reset", int'(ov), 0);
    rst_ni = 1'b1;

    // table walk
    for (int c = 0; c <= LAST_CYC; c++) begin
      @(negedge clk);
      if (c == 0) chk(ov == '0, "R1", "valid after release", int'(ov), 0);
      monitor(c);
      drive(c);
    end
    for (int r = 0; r < NR; r++)
      chk(nidx[r] == T_LEN[r], "R9", $sformatf("row %0d flits delivered", r),
          nidx[r], T_LEN[r]);

    // directed: reset between grant and head drops the grant
    @(negedge clk);
    clear_in();
    la_valid[4] = 1'b1; la_port[4] = 3'd3;
    @(negedge clk);
    clear_in();
    rst_ni = 1'b0;
    #1;
    chk(ov == '0, "R1", "valid in mid-run reset", int'(ov), 0);
    rst_ni = 1'b1;
    @(negedge clk);
    fv[4] = 1'b1; fin[4] = mk_flit(20, 0, 1, 3, 1);
    @(negedge clk);
    clear_in();
    chk(ov[3] == 1'b0, "R1", "stale grant bypassed", int'(ov[3]), 0);
    @(negedge clk);
    chk(ov[3] == 1'b1, "R1", "buffered exit after reset", int'(ov[3]), 1);
    chk(fout[3] == mk_flit(20, 0, 1, 3, 1), "R1", "buffered flit data",
        int'(fout[3]), int'(mk_flit(20, 0, 1, 3, 1)));
    repeat (2) @(negedge clk);
    chk(ov == '0, "R9", "no duplicate after directed packet", int'(ov), 0);

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_err);
    $finish;
  end
endmodule